// File: doc/BRIEF.md
# Byte-Wide Host Port Bridge

This block gives an external host a byte-wide window into a 2K-word, 16-bit shared buffer. The buffer also has a separate core-side port, so the core keeps working while the host moves data. Each 16-bit word crosses the 8-bit host bus as two strobed byte transfers. A byte-select input marks each transfer as the first or the second byte of its pair. A two-bit select input picks the target of the transfer: a small control register, the buffer address register, or buffer data. Buffer data can be reached with or without address post-increment.

The host strobe is asynchronous and is brought into the block clock domain. Each strobe that completes causes exactly one byte transfer. The control register holds three fields, and the host and the core can both reach it. The first field sets the byte order within a pair. The second is a core interrupt flag that the host sets. The third is a host interrupt flag that the core sets and the host clears.

Top module: `hpi_bridge`

## Requirements
- R1: After reset the address register is 0, the control register reads 0, and both `core_irq` and `host_int` are low.
- R2: Each completed host strobe, however long it is held low, causes exactly one byte transfer. An auto-increment data word therefore advances the address by exactly one.
- R3: A write byte with `host_hi`=0 is only latched. The buffer or register is updated when the following byte with `host_hi`=1 completes, and not before.
- R4: `host_sel` encoding: 0 = control register, 1 = data with post-increment, 2 = address register, 3 = data without increment.
- R5: Control bit 0 is the byte order. When it is 0 the first byte carries bits 7:0 of the word. When it is 1 the first byte carries bits 15:8. This applies to reads and writes of every target.
- R6: With `host_sel`=1, the address increments by one after the second byte of a data read or write. The address wraps from 2047 to 0.
- R7: With `host_sel`=3, data reads and writes leave the address unchanged.
- R8: The address register holds 11 bits. Upper bits written by the host are dropped, and they read back as zero.
- R9: A host control write with bit 1 set raises `core_irq` (control bit 1). A host write with bit 1 clear has no effect on it. A core control write with bit 1 set clears it.
- R10: A core control write with bit 2 set raises `host_int` (control bit 2). A host control write with bit 2 set clears it, and a host write with bit 2 clear has no effect. If the core set and the host clear land in the same cycle, the set wins.
- R11: The core buffer port returns read data one cycle after the address is applied. If host and core write the same word in the same cycle, the core value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_strobe_n | input | 1 | Host byte strobe, active low, asynchronous |
| host_rnw | input | 1 | 1 = host read, 0 = host write |
| host_sel | input | 2 | Target select (see R4) |
| host_hi | input | 1 | 0 = first byte of pair, 1 = second byte |
| host_din | input | 8 | Host write byte |
| host_dout | output | 8 | Host read byte |
| host_int | output | 1 | Interrupt to host (control bit 2) |
| core_irq | output | 1 | Interrupt to core (control bit 1) |
| core_ctl_we | input | 1 | Core control write strobe |
| core_ctl_wdata | input | 3 | Core control write: bit0 order, bit1 clear core_irq, bit2 set host_int |
| core_ctl_rdata | output | 16 | Control register value |
| core_mem_we | input | 1 | Core buffer write enable |
| core_mem_addr | input | 11 | Core buffer word address |
| core_mem_wdata | input | 16 | Core buffer write word |
| core_mem_rdata | output | 16 | Core buffer read word, one cycle latency |

## Verification
Two pairs of events can fall in the same clock cycle. In the first, the host's second control byte, which clears `host_int`, lands together with a core control write that sets it. In the second, a host data word and a core buffer write land on the same address together. The bench counts the synchronizer stages from the rising edge of the strobe and raises the core strobe in exactly the cycle in which the host transfer takes effect. It then judges the result at the ports: `host_int` must stay high, and a core read must return the core word.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL     = 2'd0,
    SEL_DATA_INC = 2'd1,
    SEL_ADDR     = 2'd2,
    SEL_DATA_FIX = 2'd3
  } hsel_e;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // Build a word from two bytes in arrival order.
  function automatic logic [WORD_W-1:0] join_pair(input logic [BYTE_W-1:0] first_b,
                                                  input logic [BYTE_W-1:0] second_b,
                                                  input logic high_first);
    return high_first ? {first_b, second_b} : {second_b, first_b};
  endfunction

  // Select the byte of a word that belongs at a given position in the pair.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic second,
                                                  input logic high_first);
    return (second ^ high_first) ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/hpi_strobe_sync.sv
module hpi_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic done
);
  logic [STAGES-1:0] sh;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh[0] <= 1'b1;
    else        sh[0] <= strobe_n;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[i] <= 1'b1;
      else        sh[i] <= sh[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= sh[STAGES-1];
  end

  // A completed strobe is the rising edge of the synchronized level.
  assign done = sh[STAGES-1] & ~last_q;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/hpi_byte_pair.sv
module hpi_byte_pair
  import hpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              hi,
  input  logic              rnw,
  input  logic [BYTE_W-1:0] din,
  input  logic              high_first,
  output logic              pair_done,
  output logic              wr_evt,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   first_q <= '0;
    else if (done && !hi && !rnw) first_q <= din;
  end

  assign pair_done = done & hi;
  assign wr_evt    = pair_done & ~rnw;
  assign word      = join_pair(first_q, din, high_first);
endmodule

// File: rtl/hpi_ctrl_reg.sv
module hpi_ctrl_reg
  import hpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [2:0]        host_bits,
  input  logic              core_wr,
  input  logic [2:0]        core_bits,
  output logic              order,
  output logic              core_irq,
  output logic              host_int,
  output logic [WORD_W-1:0] value
);
  logic host_sets_irq, core_clrs_irq, core_sets_int, host_clrs_int;

  assign host_sets_irq = host_wr & host_bits[1];
  assign core_clrs_irq = core_wr & core_bits[1];
  assign core_sets_int = core_wr & core_bits[2];
  assign host_clrs_int = host_wr & host_bits[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order    <= 1'b0;
      core_irq <= 1'b0;
      host_int <= 1'b0;
    end else begin
      if (host_wr)      order <= host_bits[0];
      else if (core_wr) order <= core_bits[0];
      if (host_sets_irq)      core_irq <= 1'b1;
      else if (core_clrs_irq) core_irq <= 1'b0;
      if (core_sets_int)      host_int <= 1'b1;
      else if (host_clrs_int) host_int <= 1'b0;
    end
  end

  assign value = {{(WORD_W-3){1'b0}}, host_int, core_irq, order};

  assert_host_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_sets_irq |=> core_irq);
  assert_core_raises_int_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_sets_int |=> host_int);
endmodule

// File: rtl/hpi_buffer.sv
module hpi_buffer
  import hpi_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [WORD_W-1:0] h_wdata,
  output logic [WORD_W-1:0] h_rdata,
  input  logic              c_we,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [WORD_W-1:0] c_wdata,
  output logic [WORD_W-1:0] c_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (h_we) mem[h_addr] <= h_wdata;
    if (c_we) mem[c_addr] <= c_wdata;  // core write issued last: core wins a tie
    h_rdata <= mem[h_addr];
    c_rdata <= mem[c_addr];
  end
endmodule

// File: rtl/hpi_bridge.sv
module hpi_bridge
  import hpi_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_strobe_n,
  input  logic              host_rnw,
  input  logic [1:0]        host_sel,
  input  logic              host_hi,
  input  logic [7:0]        host_din,
  output logic [7:0]        host_dout,
  output logic              host_int,
  output logic              core_irq,
  input  logic              core_ctl_we,
  input  logic [2:0]        core_ctl_wdata,
  output logic [15:0]       core_ctl_rdata,
  input  logic              core_mem_we,
  input  logic [ADDR_W-1:0] core_mem_addr,
  input  logic [15:0]       core_mem_wdata,
  output logic [15:0]       core_mem_rdata
);
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  hsel_e             sel;
  logic              done, pair_done, wr_evt, order;
  logic [WORD_W-1:0] asm_word, ctrl_val, ram_q, rd_word;
  logic [ADDR_W-1:0] host_addr;
  logic              ctl_host_wr, addr_wr, mem_host_we, inc_evt, fix_evt;

  assign sel = hsel_e'(host_sel);

  hpi_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(host_strobe_n), .done(done));

  hpi_byte_pair u_pair (
    .clk(clk), .rst_n(rst_n), .done(done), .hi(host_hi), .rnw(host_rnw),
    .din(host_din), .high_first(order), .pair_done(pair_done),
    .wr_evt(wr_evt), .word(asm_word));

  assign ctl_host_wr = wr_evt && (sel == SEL_CTRL);
  assign addr_wr     = wr_evt && (sel == SEL_ADDR);
  assign mem_host_we = wr_evt && (sel == SEL_DATA_INC || sel == SEL_DATA_FIX);
  assign inc_evt     = pair_done && (sel == SEL_DATA_INC);
  assign fix_evt     = pair_done && (sel == SEL_DATA_FIX);

  hpi_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(ctl_host_wr), .host_bits(asm_word[2:0]),
    .core_wr(core_ctl_we), .core_bits(core_ctl_wdata), .order(order),
    .core_irq(core_irq), .host_int(host_int), .value(ctrl_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_addr <= '0;
    else if (addr_wr) host_addr <= asm_word[ADDR_W-1:0];
    else if (inc_evt) host_addr <= addr_next(host_addr);
  end

  hpi_buffer #(.ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .h_we(mem_host_we), .h_addr(host_addr), .h_wdata(asm_word),
    .h_rdata(ram_q), .c_we(core_mem_we), .c_addr(core_mem_addr),
    .c_wdata(core_mem_wdata), .c_rdata(core_mem_rdata));

  always_comb begin
    case (sel)
      SEL_CTRL: rd_word = ctrl_val;
      SEL_ADDR: rd_word = {{(WORD_W-ADDR_W){1'b0}}, host_addr};
      default:  rd_word = ram_q;
    endcase
  end

  assign host_dout      = pick_byte(rd_word, host_hi, order);
  assign core_ctl_rdata = ctrl_val;

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> host_addr == ADDR_W'($past(host_addr) + 1'b1));
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fix_evt |=> $stable(host_addr));
endmodule

// File: tb/hpi_bridge_tb.sv
`timescale 1ns/1ps
module hpi_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_strobe_n = 1'b1, host_rnw = 1'b0, host_hi = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [7:0]  host_din = 8'h00, host_dout;
  logic        host_int, core_irq;
  logic        core_ctl_we = 1'b0;
  logic [2:0]  core_ctl_wdata = 3'd0;
  logic [15:0] core_ctl_rdata;
  logic        core_mem_we = 1'b0;
  logic [10:0] core_mem_addr = 11'd0;
  logic [15:0] core_mem_wdata = 16'h0, core_mem_rdata;

  int tests = 0, fails = 0;
  logic       ord_m = 1'b0;
  bit         arm_ctl = 0, arm_mem = 0;
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  hpi_bridge u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare each byte the host read against the queued expectation.
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), 32'(act_q.pop_front()), 32'(exp_q.pop_front()));
  end

  task automatic host_xfer(input logic [1:0] sel, input logic hi, input logic rnw,
                           input logic [7:0] din, input int hold, input bit fire);
    @(posedge clk); #1;
    host_sel = sel; host_hi = hi; host_rnw = rnw; host_din = din;
    host_strobe_n = 1'b0;
    repeat (hold) @(posedge clk);
    #1;
    if (rnw) act_q.push_back(host_dout);
    host_strobe_n = 1'b1;
    if (fire) begin
      // Two synchronizer stages: the transfer lands on the third edge.
      repeat (2) @(posedge clk);
      #1; core_ctl_we = arm_ctl; core_mem_we = arm_mem;
      @(posedge clk);
      #1; core_ctl_we = 1'b0; core_mem_we = 1'b0;
    end
    repeat (5) @(posedge clk);
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [15:0] w, input bit fire);
    host_xfer(sel, 1'b0, 1'b0, ord_m ? w[15:8] : w[7:0], 4, 0);
    host_xfer(sel, 1'b1, 1'b0, ord_m ? w[7:0] : w[15:8], 4, fire);
  endtask

  task automatic host_read(input logic [1:0] sel, input logic [15:0] w, input string tag);
    exp_q.push_back(ord_m ? w[15:8] : w[7:0]); tag_q.push_back(tag);
    exp_q.push_back(ord_m ? w[7:0] : w[15:8]); tag_q.push_back(tag);
    host_xfer(sel, 1'b0, 1'b1, 8'h00, 4, 0);
    host_xfer(sel, 1'b1, 1'b1, 8'h00, 4, 0);
  endtask

  task automatic core_write(input logic [10:0] a, input logic [15:0] d);
    @(posedge clk); #1; core_mem_we = 1'b1; core_mem_addr = a; core_mem_wdata = d;
    @(posedge clk); #1; core_mem_we = 1'b0;
  endtask

  task automatic core_read(input logic [10:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #1; core_mem_addr = a;
    @(posedge clk); #1;
    check(tag, 32'(core_mem_rdata), 32'(exp));
  endtask

  task automatic core_ctl(input logic [2:0] v);
    @(posedge clk); #1; core_ctl_we = 1'b1; core_ctl_wdata = v;
    @(posedge clk); #1; core_ctl_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R1 host_int", 32'(host_int), 0);
    check("R1 core_irq", 32'(core_irq), 0);
    check("R1 ctrl", 32'(core_ctl_rdata), 0);
    host_read(2'd2, 16'h0000, "R1 addr");

    // R4 / R8: address register, 11 bits
    host_write(2'd2, 16'h0005, 0);
    host_read(2'd2, 16'h0005, "R4 addr readback");
    host_write(2'd2, 16'hFFFF, 0);
    host_read(2'd2, 16'h07FF, "R8 addr mask");

    // R5 order 0, R6 increment on write and read
    host_write(2'd2, 16'd10, 0);
    host_write(2'd1, 16'h1234, 0);
    core_read(11'd10, 16'h1234, "R5 order0 write");
    host_read(2'd2, 16'd11, "R6 inc after write");
    host_write(2'd2, 16'd10, 0);
    host_read(2'd1, 16'h1234, "R6 data read");
    host_read(2'd2, 16'd11, "R6 inc after read");

    // R3: first byte alone touches nothing
    core_write(11'd20, 16'h5555);
    host_write(2'd2, 16'd20, 0);
    host_xfer(2'd3, 1'b0, 1'b0, 8'hAA, 4, 0);
    core_read(11'd20, 16'h5555, "R3 first byte only");
    host_xfer(2'd3, 1'b1, 1'b0, 8'hBB, 4, 0);
    core_read(11'd20, 16'hBBAA, "R3 second byte commits");

    // R2: long strobes still give one transfer each
    host_write(2'd2, 16'd50, 0);
    host_xfer(2'd1, 1'b0, 1'b0, 8'h11, 25, 0);
    host_xfer(2'd1, 1'b1, 1'b0, 8'h22, 25, 0);
    host_read(2'd2, 16'd51, "R2 single step");
    core_read(11'd50, 16'h2211, "R2 data");

    // R7: no increment
    host_write(2'd2, 16'd30, 0);
    host_write(2'd3, 16'hCAFE, 0);
    core_read(11'd30, 16'hCAFE, "R7 data");
    host_read(2'd3, 16'hCAFE, "R7 read");
    host_read(2'd2, 16'd30, "R7 addr held");

    // R5 order 1
    host_write(2'd0, 16'h0001, 0); ord_m = 1'b1;
    check("R5 order bit", 32'(core_ctl_rdata), 32'h1);
    host_write(2'd3, 16'h1357, 0);
    core_read(11'd30, 16'h1357, "R5 order1 write");
    host_read(2'd3, 16'h1357, "R5 order1 read");

    // R6 wrap
    host_write(2'd2, 16'd2047, 0);
    host_write(2'd1, 16'h0F0F, 0);
    host_read(2'd2, 16'd0, "R6 wrap");
    core_read(11'd2047, 16'h0F0F, "R6 wrap data");

    // R9
    host_write(2'd0, 16'h0003, 0);
    check("R9 raise", 32'(core_irq), 1);
    host_write(2'd0, 16'h0001, 0);
    check("R9 host zero no effect", 32'(core_irq), 1);
    core_ctl(3'b011);
    check("R9 core clear", 32'(core_irq), 0);

    // R10
    core_ctl(3'b101);
    check("R10 core set", 32'(host_int), 1);
    host_read(2'd0, 16'h0005, "R10 ctrl read");
    host_write(2'd0, 16'h0001, 0);
    check("R10 host zero no effect", 32'(host_int), 1);
    host_write(2'd0, 16'h0005, 0);
    check("R10 host clear", 32'(host_int), 0);
    core_ctl(3'b101);
    core_ctl_wdata = 3'b101; arm_ctl = 1;
    host_write(2'd0, 16'h0005, 1);
    arm_ctl = 0;
    check("R10 set wins collision", 32'(host_int), 1);

    // R11: same-address collision, core wins
    host_write(2'd2, 16'd40, 0);
    core_mem_addr = 11'd40; core_mem_wdata = 16'h2222; arm_mem = 1;
    host_write(2'd3, 16'h1111, 1);
    arm_mem = 0;
    core_read(11'd40, 16'h2222, "R11 core wins");
    core_write(11'd41, 16'h7777);
    core_read(11'd41, 16'h7777, "R11 core port");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule